// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Bridge

This block lets a local master read and write 32-bit registers inside a switch whose registers are reachable only through 16-bit management (MDIO) transactions. The switch registers sit in pages. For each local request the bridge takes the word address apart into a page number, a PHY-select field and a register field. It then issues a page-select write, waits a fixed settle interval, and moves the two 16-bit halves of the register with two more MDIO commands.

The local side is a simple request/acknowledge port. The master pulses `reqValid` with the address, the direction and the write data. It receives a one-cycle `reqAck` when the whole sequence is finished. On the far side the block drives the command port of a separate MDIO frame engine: one `cmdStart` pulse per command, with the PHY address, register number, direction and data held steady. The engine answers with `cmdDone` and, for reads, `cmdRdata`. The block accepts one request at a time. A read whose two halves both come back all ones is marked with an error flag.

Top module: `paged_mdio_bridge`

## Requirements
- R1: The word address `reqWordAddr[15:0]` splits into three fields. The low register number is `{reqWordAddr[3:0],1'b0}`. The PHY-select field is `reqWordAddr[6:4]`. The page number is `reqWordAddr[15:7]`.
- R2: The first MDIO command of every request is a write to PHY address 0x18, register 0, with data equal to the 9-bit page number zero-extended to 16 bits.
- R3: After the page command is done, no data command starts until at least `SETTLE_CYCLES`+1 clock cycles have passed since the cycle in which `cmdDone` was high.
- R4: Data commands use PHY address 0x10 OR the PHY-select field. The low half of the register is at the low register number, and the high half is at that number plus one.
- R5: A read fetches the low half first, then the high half, and returns `{high, low}` on `rspRdata`.
- R6: A write sends `reqWdata[31:16]` to the high register first, then `reqWdata[15:0]` to the low register.
- R7: Each command is a one-cycle `cmdStart` pulse. A new `cmdStart` never comes while an earlier command has not yet returned `cmdDone`.
- R8: `reqAck` is high for exactly one cycle, the cycle after the last command's `cmdDone`. `rspRdata` and `rspErr` are valid from that cycle and hold until the next acknowledge. A write leaves `rspRdata` unchanged.
- R9: `rspErr` is set at the acknowledge of a read whose two halves are both 0xFFFF. It is cleared at the acknowledge of any write, or of any read with other data.
- R10: A `reqValid` pulse that arrives while a request is in progress is ignored. It produces no command and no acknowledge, and it changes no register.
- R11: Out of reset, `reqAck`, `cmdStart` and `rspErr` are low and `rspRdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request pulse, taken when the bridge is idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWordAddr | input | 16 | 32-bit-word register address |
| reqWdata | input | 32 | Write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data of the last read |
| rspErr | output | 1 | Last read returned all ones |
| cmdStart | output | 1 | Start pulse to the MDIO frame engine |
| cmdWrite | output | 1 | Command direction, 1 = write |
| cmdPhy | output | 5 | Command PHY address |
| cmdReg | output | 5 | Command register number |
| cmdWdata | output | 16 | Command write data |
| cmdDone | input | 1 | Engine has finished the command |
| cmdRdata | input | 16 | Engine read data, valid with cmdDone |

## Verification
A wrong sequencer state shows up at the command port within the same request. It appears as a data command before the page write, a start that comes too early after the page is done, a second start while the engine is busy, or halves sent in the wrong order. Each of these is visible on the first command that goes wrong. A wrong address split or a swapped half reaches the local port at the next read-back, as wrong `rspRdata` or a spurious `rspErr`. A sequencer that fails to return to idle, or that picks up a request while busy, is seen as a missing or extra `reqAck` or an unexpected `cmdStart`, at the latest a few cycles after the ignored pulse.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE_GO,
    ST_PAGE_WAIT,
    ST_SETTLE,
    ST_FIRST_GO,
    ST_FIRST_WAIT,
    ST_SECOND_GO,
    ST_SECOND_WAIT
  } step_t;

  typedef enum logic [1:0] {
    SEL_PAGE,
    SEL_FIRST,
    SEL_SECOND
  } cmdSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    capture;     // latch the local request
    logic    startCmd;    // pulse cmdStart
    cmdSel_t sel;         // which command the datapath presents
    logic    latchFirst;  // keep first read half
    logic    finish;      // last command done: acknowledge
  } ctrlStrobes_t;

endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         cmdDone,
  output ctrlStrobes_t strb
);

  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  step_t state, stateNext;
  logic [CNT_W-1:0] settleCnt;
  logic settleDone;

  assign settleDone = (settleCnt == CNT_LAST);

  always_comb begin
    stateNext       = state;
    strb            = '0;
    strb.sel        = SEL_PAGE;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          stateNext    = ST_PAGE_GO;
        end
      end
      ST_PAGE_GO: begin
        strb.startCmd = 1'b1;
        stateNext     = ST_PAGE_WAIT;
      end
      ST_PAGE_WAIT: begin
        if (cmdDone) stateNext = ST_SETTLE;
      end
      ST_SETTLE: begin
        strb.sel = SEL_FIRST;
        if (settleDone) stateNext = ST_FIRST_GO;
      end
      ST_FIRST_GO: begin
        strb.sel      = SEL_FIRST;
        strb.startCmd = 1'b1;
        stateNext     = ST_FIRST_WAIT;
      end
      ST_FIRST_WAIT: begin
        strb.sel = SEL_FIRST;
        if (cmdDone) begin
          strb.latchFirst = 1'b1;
          stateNext       = ST_SECOND_GO;
        end
      end
      ST_SECOND_GO: begin
        strb.sel      = SEL_SECOND;
        strb.startCmd = 1'b1;
        stateNext     = ST_SECOND_WAIT;
      end
      ST_SECOND_WAIT: begin
        strb.sel = SEL_SECOND;
        if (cmdDone) begin
          strb.finish = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
    end
  end

endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
#(
  parameter int           PAGE_W        = 9,
  parameter int           PHYSEL_W      = 3,
  parameter int           REGF_W        = 4,
  parameter int           DATA_W        = 32,
  parameter int           PHY_W         = 5,
  parameter logic [4:0]   PAGE_PHY      = 5'h18,
  parameter logic [4:0]   DATA_PHY_BASE = 5'h10,
  localparam int          WADDR_W       = PAGE_W + PHYSEL_W + REGF_W,
  localparam int          HALF_W        = DATA_W / 2,
  localparam int          REG_W         = REGF_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic                reqWrite,
  input  logic [WADDR_W-1:0]  reqWordAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [HALF_W-1:0]   cmdRdata,
  output logic                cmdWrite,
  output logic [PHY_W-1:0]    cmdPhy,
  output logic [REG_W-1:0]    cmdReg,
  output logic [HALF_W-1:0]   cmdWdata,
  output logic                reqAck,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                rspErr
);

  logic                isWrite;
  logic [PAGE_W-1:0]   pageNum;
  logic [PHYSEL_W-1:0] phySel;
  logic [REG_W-1:0]    regLow;
  logic [REG_W-1:0]    regHigh;
  logic [DATA_W-1:0]   wrData;
  logic [HALF_W-1:0]   firstHalf;
  logic [PHY_W-1:0]    dataPhy;

  // low register number is always even, so OR-ing in bit 0 gives +1
  assign regHigh = regLow | REG_W'(1);
  assign dataPhy = PHY_W'(DATA_PHY_BASE) | PHY_W'(phySel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWrite <= 1'b0;
      pageNum <= '0;
      phySel  <= '0;
      regLow  <= '0;
      wrData  <= '0;
    end else if (strb.capture) begin
      isWrite <= reqWrite;
      pageNum <= reqWordAddr[WADDR_W-1 -: PAGE_W];
      phySel  <= reqWordAddr[REGF_W +: PHYSEL_W];
      regLow  <= {reqWordAddr[REGF_W-1:0], 1'b0};
      wrData  <= reqWdata;
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_FIRST: begin
        cmdWrite = isWrite;
        cmdPhy   = dataPhy;
        cmdReg   = isWrite ? regHigh : regLow;
        cmdWdata = wrData[DATA_W-1 -: HALF_W];
      end
      SEL_SECOND: begin
        cmdWrite = isWrite;
        cmdPhy   = dataPhy;
        cmdReg   = isWrite ? regLow : regHigh;
        cmdWdata = wrData[HALF_W-1:0];
      end
      default: begin
        cmdWrite = 1'b1;
        cmdPhy   = PHY_W'(PAGE_PHY);
        cmdReg   = '0;
        cmdWdata = HALF_W'(pageNum);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstHalf <= '0;
      reqAck    <= 1'b0;
      rspRdata  <= '0;
      rspErr    <= 1'b0;
    end else begin
      reqAck <= strb.finish;
      if (strb.latchFirst) firstHalf <= cmdRdata;
      if (strb.finish) begin
        if (isWrite) begin
          rspErr <= 1'b0;
        end else begin
          rspRdata <= {cmdRdata, firstHalf};
          rspErr   <= (&firstHalf) && (&cmdRdata);
        end
      end
    end
  end

endmodule

// File: rtl/paged_mdio_bridge.sv
module paged_mdio_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int         SETTLE_CYCLES = 50000,
  parameter int         PAGE_W        = 9,
  parameter int         PHYSEL_W      = 3,
  parameter int         REGF_W        = 4,
  parameter int         DATA_W        = 32,
  parameter int         PHY_W         = 5,
  parameter logic [4:0] PAGE_PHY      = 5'h18,
  parameter logic [4:0] DATA_PHY_BASE = 5'h10,
  localparam int        WADDR_W       = PAGE_W + PHYSEL_W + REGF_W,
  localparam int        HALF_W        = DATA_W / 2,
  localparam int        REG_W         = REGF_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [WADDR_W-1:0] reqWordAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               reqAck,
  output logic [DATA_W-1:0]  rspRdata,
  output logic               rspErr,
  output logic               cmdStart,
  output logic               cmdWrite,
  output logic [PHY_W-1:0]   cmdPhy,
  output logic [REG_W-1:0]   cmdReg,
  output logic [HALF_W-1:0]  cmdWdata,
  input  logic               cmdDone,
  input  logic [HALF_W-1:0]  cmdRdata
);

  ctrlStrobes_t strb;

  mdio_bridge_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .cmdDone (cmdDone),
    .strb    (strb)
  );

  mdio_bridge_dp #(
    .PAGE_W       (PAGE_W),
    .PHYSEL_W     (PHYSEL_W),
    .REGF_W       (REGF_W),
    .DATA_W       (DATA_W),
    .PHY_W        (PHY_W),
    .PAGE_PHY     (PAGE_PHY),
    .DATA_PHY_BASE(DATA_PHY_BASE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqWrite   (reqWrite),
    .reqWordAddr(reqWordAddr),
    .reqWdata   (reqWdata),
    .cmdRdata   (cmdRdata),
    .cmdWrite   (cmdWrite),
    .cmdPhy     (cmdPhy),
    .cmdReg     (cmdReg),
    .cmdWdata   (cmdWdata),
    .reqAck     (reqAck),
    .rspRdata   (rspRdata),
    .rspErr     (rspErr)
  );

  assign cmdStart = strb.startCmd;

endmodule

// File: rtl/paged_mdio_bridge_chk.sv
module paged_mdio_bridge_chk #(
  parameter int         SETTLE_CYCLES = 50000,
  parameter logic [4:0] PAGE_PHY      = 5'h18
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqAck,
  input logic       rspErr,
  input logic       cmdStart,
  input logic       cmdDone,
  input logic       cmdWrite,
  input logic [4:0] cmdPhy,
  input logic [4:0] cmdReg
);

  localparam int GAP_W = $clog2(SETTLE_CYCLES + 2);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(SETTLE_CYCLES);

  logic             engBusy;
  logic             lastWasPage;
  logic             pageSeen;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engBusy     <= 1'b0;
      lastWasPage <= 1'b0;
      pageSeen    <= 1'b0;
      gapCnt      <= '0;
    end else begin
      if (cmdStart)     engBusy <= 1'b1;
      else if (cmdDone) engBusy <= 1'b0;
      if (cmdStart) lastWasPage <= (cmdPhy == PAGE_PHY);
      if (reqAck) pageSeen <= 1'b0;
      else if (cmdStart && cmdPhy == PAGE_PHY) pageSeen <= 1'b1;
      if (cmdDone && lastWasPage) gapCnt <= '0;
      else if (gapCnt != GAP_SAT) gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> !engBusy);  // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);  // R7
  AST_PAGE_CMD_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdPhy == PAGE_PHY) |-> (cmdWrite && cmdReg == 5'd0));  // R2
  AST_PAGE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdPhy != PAGE_PHY) |-> pageSeen);  // R2
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdPhy != PAGE_PHY) |-> (gapCnt == GAP_SAT));  // R3
  AST_DATA_PHY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdPhy != PAGE_PHY) |-> (cmdPhy[4:3] == 2'b10));  // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);  // R8
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> $past(cmdDone));  // R8
  AST_ERR_AT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspErr) |-> reqAck);  // R9

endmodule

bind paged_mdio_bridge paged_mdio_bridge_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .PAGE_PHY     (PAGE_PHY)
) uChk (.*);

// File: tb/paged_mdio_bridge_test.sv
module paged_mdio_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqWrite;
  logic [15:0] reqWordAddr;
  logic [31:0] reqWdata;
  logic        reqAck;
  logic [31:0] rspRdata;
  logic        rspErr;
  logic        cmdStart;
  logic        cmdWrite;
  logic [4:0]  cmdPhy;
  logic [4:0]  cmdReg;
  logic [15:0] cmdWdata;
  logic        cmdDone;
  logic [15:0] cmdRdata;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int pageDoneCyc = 0;
  int cmdCount = 0;
  bit finished = 0;
  logic [31:0] lastRead = 32'h0;

  typedef struct { bit wr; logic [4:0] phy; logic [4:0] rg; logic [15:0] data; string tag; } cmd_t;
  typedef struct { bit wr; logic [31:0] data; bit err; string tag; } rsp_t;

  cmd_t expCmds[$];
  rsp_t expRsps[$];
  logic [15:0] swMem [int];
  logic [31:0] shadow [int];
  logic [8:0] curPage = 9'd0;

  paged_mdio_bridge #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWordAddr(reqWordAddr), .reqWdata(reqWdata), .reqAck(reqAck),
    .rspRdata(rspRdata), .rspErr(rspErr), .cmdStart(cmdStart),
    .cmdWrite(cmdWrite), .cmdPhy(cmdPhy), .cmdReg(cmdReg),
    .cmdWdata(cmdWdata), .cmdDone(cmdDone), .cmdRdata(cmdRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int memKey(logic [8:0] pg, logic [4:0] ph, logic [4:0] rg);
    return int'({pg, ph, rg});
  endfunction

  // R1 field layout, used to place words directly in the switch model
  task automatic preload(logic [15:0] wa, logic [31:0] val);
    logic [4:0] ph, rlo;
    ph  = {2'b10, wa[6:4]};
    rlo = {wa[3:0], 1'b0};
    swMem[memKey(wa[15:7], ph, rlo)]        = val[15:0];
    swMem[memKey(wa[15:7], ph, rlo | 5'd1)] = val[31:16];
    shadow[int'(wa)] = val;
  endtask

  task automatic pushExpect(bit wr, logic [15:0] wa, logic [31:0] wd, string tag);
    cmd_t c;
    rsp_t r;
    logic [4:0] ph, rlo;
    ph  = {2'b10, wa[6:4]};
    rlo = {wa[3:0], 1'b0};
    c = '{1'b1, 5'h18, 5'd0, {7'd0, wa[15:7]}, {tag, " R2"}};
    expCmds.push_back(c);
    if (wr) begin
      c = '{1'b1, ph, rlo | 5'd1, wd[31:16], {tag, " R6 high first"}};
      expCmds.push_back(c);
      c = '{1'b1, ph, rlo, wd[15:0], {tag, " R6 low second"}};
      expCmds.push_back(c);
      shadow[int'(wa)] = wd;
      r = '{1'b1, 32'h0, 1'b0, tag};
    end else begin
      c = '{1'b0, ph, rlo, 16'h0, {tag, " R5 low first"}};
      expCmds.push_back(c);
      c = '{1'b0, ph, rlo | 5'd1, 16'h0, {tag, " R5 high second"}};
      expCmds.push_back(c);
      if (shadow.exists(int'(wa))) r = '{1'b0, shadow[int'(wa)], shadow[int'(wa)] == 32'hFFFF_FFFF, tag};
      else                         r = '{1'b0, 32'hFFFF_FFFF, 1'b1, tag};
    end
    expRsps.push_back(r);
  endtask

  task automatic pulseReq(bit wr, logic [15:0] wa, logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWordAddr = wa; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDrain();
    while (expRsps.size() != 0 || expCmds.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doAccess(bit wr, logic [15:0] wa, logic [31:0] wd, string tag);
    pushExpect(wr, wa, wd, tag);
    pulseReq(wr, wa, wd);
    waitDrain();
  endtask

  // MDIO frame engine and switch model, comparing commands against the queue
  initial begin
    cmdDone  = 1'b0;
    cmdRdata = 16'h0;
    forever begin
      @(negedge clk);
      cmdDone = 1'b0;
      if (rstN === 1'b1 && cmdStart === 1'b1) begin
        cmd_t e;
        logic cw;
        logic [4:0] cp, cr;
        logic [15:0] cd;
        int lat;
        cw = cmdWrite; cp = cmdPhy; cr = cmdReg; cd = cmdWdata;
        if (expCmds.size() == 0) begin
          total++; bad++;
          $display("FAIL R10 unexpected command actual=phy %h reg %h expected=none", cp, cr);
        end else begin
          e = expCmds.pop_front();
          check({e.tag, " R4 phy"}, 32'(cp), 32'(e.phy));
          check({e.tag, " R1 reg"}, 32'(cr), 32'(e.rg));
          check({e.tag, " dir"}, 32'(cw), 32'(e.wr));
          if (e.wr) check({e.tag, " data"}, 32'(cd), 32'(e.data));
          if (cp != 5'h18) begin
            total++;
            if (cyc - pageDoneCyc < SETTLE + 1) begin
              bad++;
              $display("FAIL R3 settle gap actual=%0d expected>=%0d", cyc - pageDoneCyc, SETTLE + 1);
            end
          end
        end
        lat = 1 + (cmdCount % 4);
        cmdCount++;
        repeat (lat) @(negedge clk);
        if (cw) begin
          if (cp == 5'h18 && cr == 5'd0) curPage = cd[8:0];
          else swMem[memKey(curPage, cp, cr)] = cd;
        end else begin
          if (swMem.exists(memKey(curPage, cp, cr))) cmdRdata = swMem[memKey(curPage, cp, cr)];
          else cmdRdata = 16'hFFFF;
        end
        cmdDone = 1'b1;
        if (cp == 5'h18) pageDoneCyc = cyc;
      end
    end
  end

  // response monitor
  bit prevAck = 1'b0;
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (reqAck === 1'b1) begin
        if (prevAck) begin
          total++; bad++;
          $display("FAIL R8 ack longer than one cycle actual=1 expected=0");
        end else if (expRsps.size() == 0) begin
          total++; bad++;
          $display("FAIL R10 unexpected ack actual=1 expected=0");
        end else begin
          rsp_t r;
          r = expRsps.pop_front();
          check({r.tag, " R9 err"}, 32'(rspErr), 32'(r.err));
          if (r.wr) begin
            check({r.tag, " R8 data held on write"}, rspRdata, lastRead);
          end else begin
            check({r.tag, " R5 read data"}, rspRdata, r.data);
            lastRead = r.data;
          end
        end
      end
      prevAck = (reqAck === 1'b1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqWordAddr = 16'h0; reqWdata = 32'h0;
    repeat (3) @(negedge clk);
    check("R11 reqAck", 32'(reqAck), 32'h0);
    check("R11 cmdStart", 32'(cmdStart), 32'h0);
    check("R11 rspErr", 32'(rspErr), 32'h0);
    check("R11 rspRdata", rspRdata, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 boundaries of the address split
    preload(16'h0000, 32'hA5A5_5A5A);
    doAccess(1'b0, 16'h0000, 32'h0, "R1 read lowest");
    preload(16'hFFFF, 32'h1357_9BDF);
    doAccess(1'b0, 16'hFFFF, 32'h0, "R1 read highest");

    // write/read round trips
    doAccess(1'b1, 16'h1234, 32'hDEAD_BEEF, "R6 write");
    doAccess(1'b0, 16'h1234, 32'h0, "R5 readback");
    doAccess(1'b1, 16'h0081, 32'h0102_0304, "R6 write page1");
    doAccess(1'b0, 16'h0081, 32'h0, "R5 readback page1");

    // R9 error flag
    doAccess(1'b0, 16'h4321, 32'h0, "R9 read unwritten");
    doAccess(1'b1, 16'h0042, 32'h0BAD_F00D, "R9 write clears err");
    doAccess(1'b1, 16'h0050, 32'h1234_FFFF, "R9 write low ones");
    doAccess(1'b0, 16'h0050, 32'h0, "R9 read low ones");
    doAccess(1'b1, 16'h0051, 32'hFFFF_1234, "R9 write high ones");
    doAccess(1'b0, 16'h0051, 32'h0, "R9 read high ones");
    doAccess(1'b0, 16'h4322, 32'h0, "R9 read unwritten again");
    doAccess(1'b0, 16'h0042, 32'h0, "R9 read clears err");

    // R10 request during a transfer is ignored
    pushExpect(1'b1, 16'h0123, 32'hCAFE_0001, "R10 primary write");
    pulseReq(1'b1, 16'h0123, 32'hCAFE_0001);
    repeat (3) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqWordAddr = 16'h7777; reqWdata = 32'h5555_AAAA;
    @(negedge clk);
    reqValid = 1'b0;
    waitDrain();
    repeat (30) @(negedge clk);
    check("R10 no extra commands", 32'(expCmds.size()), 32'h0);
    doAccess(1'b0, 16'h7777, 32'h0, "R10 ignored write left no data");
    doAccess(1'b0, 16'h0123, 32'h0, "R10 primary readback");

    // same page, every PHY-select value
    for (int i = 0; i < 8; i++)
      doAccess(1'b1, {9'd3, 3'(i), 4'd5}, 32'h1000_0000 + 32'(i * 32'h0001_0101), "R4 sweep write");
    for (int i = 0; i < 8; i++)
      doAccess(1'b0, {9'd3, 3'(i), 4'd5}, 32'h0, "R4 sweep read");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule